// File: doc/BRIEF.md
# Isolated Data Channel Pulse Link

This block carries one logic level across an isolation barrier as a stream of single-cycle pulses. The transmit half samples a data input. It emits a pulse whenever that input changes, and it emits a pulse once when its side powers up. While the input holds still, it repeats the current level at a fixed cadence. Each pulse carries the level being conveyed.

The receive half rebuilds the level from those pulses. Each side has its own undervoltage-lockout flag. While its flag is low, a side is idle. The received output comes up low and stays low until the first pulse arrives, and after that it holds the last level it received. If the line stays quiet for longer than the quiet window, the output drops back to low, even though power is still good.

The two halves share a clock but are linked only through the pulse pins. The barrier sits between `tx_pulse_*` and `rx_pulse_*`. Between refreshes the receiver tolerates the loss of any single pulse, because its quiet window is set to twice the refresh period plus a margin.

Top module: `iso_chan_link`

## Requirements
- R1: While `rst` is high, `data_out`, `data_valid` and `tx_pulse_vld` are all 0.
- R2: While `sec_pwr_ok` is 0, `data_out` and `data_valid` are 0 one cycle later, and a received pulse in that state has no effect.
- R3: After `sec_pwr_ok` rises, `data_out` and `data_valid` stay 0 until a pulse is sampled. The cycle after the first pulse, `data_valid` is 1 and `data_out` equals that pulse's level.
- R4: While the receiver is valid, every sampled pulse, whether an edge or a refresh, sets `data_out` to its level in the next cycle, and `data_valid` stays 1.
- R5: Let the last pulse be sampled at edge E. With `WIN = 2*REFRESH_CYC + WDOG_MARGIN`, `data_out` and `data_valid` are still unchanged after edge E+WIN-1 and are both 0 after edge E+WIN.
- R6: A gap of up to `2*REFRESH_CYC` cycles between pulses, such as one missing refresh, leaves `data_valid` at 1 and `data_out` unchanged.
- R7: When `sec_pwr_ok` falls, the output held until then is replaced by 0 and `data_valid` by 0 in the next cycle.
- R8: While `pri_pwr_ok` is 0, `tx_pulse_vld` is 0, whatever `data_in` does.
- R9: On the first cycle that `pri_pwr_ok` is sampled high, a pulse is emitted one cycle later, with `tx_pulse_lvl` equal to `data_in`.
- R10: When `data_in` changes while the transmitter is powered, a pulse carrying the new level appears in the cycle after the change is sampled.
- R11: With `data_in` static, a refresh pulse carrying the current level appears exactly `REFRESH_CYC` cycles after the previous pulse, and `tx_pulse_vld` is 0 in between.
- R12: With the pulse pins looped back, a change on `data_in` reaches `data_out` two cycles after it is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pri_pwr_ok | input | 1 | Transmit-side undervoltage flag, 1 = supply good |
| data_in | input | 1 | Level to be carried across |
| tx_pulse_vld | output | 1 | Transmit pulse strobe, one cycle wide |
| tx_pulse_lvl | output | 1 | Level carried by the transmit pulse |
| sec_pwr_ok | input | 1 | Receive-side undervoltage flag, 1 = supply good |
| rx_pulse_vld | input | 1 | Received pulse strobe |
| rx_pulse_lvl | input | 1 | Level carried by the received pulse |
| data_out | output | 1 | Reconstructed level, low by default |
| data_valid | output | 1 | High from the first accepted pulse until expiry or power loss |

## Verification
The bench builds the block with `REFRESH_CYC = 16` and `WDOG_MARGIN = 4`, which gives a quiet window of 36 cycles. With these values, repeated refreshes, a refresh deliberately dropped at the barrier, and a full quiet-window expiry all fit inside a few hundred cycles. That makes the boundary cycles either side of expiry and of each refresh directly observable. The pulse pins are driven either by the loopback from the transmit half or by direct injection. Injection lets the receiver be tested on its own, including with pulses sent while it is unpowered.

// File: rtl/iso_chan_pkg.sv
package iso_chan_pkg;

    // One barrier-crossing event: a strobe and the level it conveys.
    typedef struct packed {
        logic vld;
        logic lvl;
    } pulse_t;

    // Reason the transmitter emits a pulse this cycle.
    typedef enum logic [1:0] {
        PK_NONE    = 2'd0,
        PK_PRIME   = 2'd1,
        PK_EDGE    = 2'd2,
        PK_REFRESH = 2'd3
    } pulse_kind_e;

    // Receiver condition.
    typedef enum logic [1:0] {
        RX_OFF  = 2'd0,
        RX_WAIT = 2'd1,
        RX_LIVE = 2'd2
    } rx_state_e;

    // Quiet window: strictly longer than two refresh periods.
    function automatic int unsigned quiet_window(input int unsigned refresh_cyc,
                                                 input int unsigned margin);
        return 2 * refresh_cyc + ((margin == 0) ? 1 : margin);
    endfunction

    function automatic int unsigned span_width(input int unsigned limit);
        return (limit > 1) ? $clog2(limit) : 1;
    endfunction

endpackage

// File: rtl/iso_span_counter.sv
module iso_span_counter #(
    parameter int unsigned LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    output logic terminal
);
    import iso_chan_pkg::*;

    localparam int unsigned CW = span_width(LIMIT);
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    // Counts cycles since the last clear and saturates at LIMIT-1.
    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt_q <= '0;
        end else if (cnt_q != LAST) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign terminal = (cnt_q == LAST);

endmodule

// File: rtl/iso_tx_encoder.sv
module iso_tx_encoder #(
    parameter int unsigned REFRESH_CYC = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pwr_ok,
    input  logic                  din,
    output iso_chan_pkg::pulse_t  pulse_o
);
    import iso_chan_pkg::*;

    logic        primed_q;
    logic        din_q;
    logic        refresh_due;
    pulse_kind_e kind;
    pulse_t      pulse_q;

    // Priority: power gate, first sample, input change, refresh cadence.
    always_comb begin
        if (!pwr_ok) begin
            kind = PK_NONE;
        end else if (!primed_q) begin
            kind = PK_PRIME;
        end else if (din != din_q) begin
            kind = PK_EDGE;
        end else if (refresh_due) begin
            kind = PK_REFRESH;
        end else begin
            kind = PK_NONE;
        end
    end

    iso_span_counter #(.LIMIT(REFRESH_CYC)) u_refresh (
        .clk      (clk),
        .rst      (rst),
        .clear    (!pwr_ok || (kind != PK_NONE)),
        .terminal (refresh_due)
    );

    always_ff @(posedge clk) begin
        if (rst || !pwr_ok) begin
            primed_q <= 1'b0;
            din_q    <= 1'b0;
            pulse_q  <= '0;
        end else begin
            primed_q    <= 1'b1;
            din_q       <= din;
            pulse_q.vld <= (kind != PK_NONE);
            pulse_q.lvl <= din;
        end
    end

    assign pulse_o = pulse_q;

endmodule

// File: rtl/iso_rx_keeper.sv
module iso_rx_keeper #(
    parameter int unsigned WDOG_CYC = 36
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  pwr_ok,
    input  iso_chan_pkg::pulse_t  pulse_i,
    output logic                  dout,
    output logic                  valid
);
    import iso_chan_pkg::*;

    rx_state_e state_q, state_d;
    logic      dout_q, dout_d;
    logic      quiet_full;
    logic      expire;

    iso_span_counter #(.LIMIT(WDOG_CYC)) u_quiet (
        .clk      (clk),
        .rst      (rst),
        .clear    (!pwr_ok || pulse_i.vld || (state_q != RX_LIVE)),
        .terminal (quiet_full)
    );

    assign expire = (state_q == RX_LIVE) && quiet_full && !pulse_i.vld;

    always_comb begin
        state_d = state_q;
        dout_d  = dout_q;
        if (!pwr_ok) begin
            state_d = RX_OFF;
            dout_d  = 1'b0;
        end else if (pulse_i.vld) begin
            state_d = RX_LIVE;
            dout_d  = pulse_i.lvl;
        end else if (state_q == RX_OFF || expire) begin
            state_d = RX_WAIT;
            dout_d  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= RX_OFF;
            dout_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            dout_q  <= dout_d;
        end
    end

    assign dout  = dout_q;
    assign valid = (state_q == RX_LIVE);

endmodule

// File: rtl/iso_chan_link.sv
module iso_chan_link #(
    parameter int unsigned REFRESH_CYC = 200,
    parameter int unsigned WDOG_MARGIN = 40
) (
    input  logic clk,
    input  logic rst,
    input  logic pri_pwr_ok,
    input  logic data_in,
    output logic tx_pulse_vld,
    output logic tx_pulse_lvl,
    input  logic sec_pwr_ok,
    input  logic rx_pulse_vld,
    input  logic rx_pulse_lvl,
    output logic data_out,
    output logic data_valid
);
    import iso_chan_pkg::*;

    localparam int unsigned WDOG_CYC = quiet_window(REFRESH_CYC, WDOG_MARGIN);

    pulse_t tx_pulse;
    pulse_t rx_pulse;

    iso_tx_encoder #(.REFRESH_CYC(REFRESH_CYC)) u_tx (
        .clk     (clk),
        .rst     (rst),
        .pwr_ok  (pri_pwr_ok),
        .din     (data_in),
        .pulse_o (tx_pulse)
    );

    assign tx_pulse_vld = tx_pulse.vld;
    assign tx_pulse_lvl = tx_pulse.lvl;

    assign rx_pulse.vld = rx_pulse_vld;
    assign rx_pulse.lvl = rx_pulse_lvl;

    iso_rx_keeper #(.WDOG_CYC(WDOG_CYC)) u_rx (
        .clk     (clk),
        .rst     (rst),
        .pwr_ok  (sec_pwr_ok),
        .pulse_i (rx_pulse),
        .dout    (data_out),
        .valid   (data_valid)
    );

endmodule

// File: rtl/iso_chan_link_chk.sv
module iso_chan_link_chk #(
    parameter int unsigned REFRESH_CYC = 200,
    parameter int unsigned WDOG_MARGIN = 40
) (
    input logic clk,
    input logic rst,
    input logic pri_pwr_ok,
    input logic data_in,
    input logic tx_pulse_vld,
    input logic tx_pulse_lvl,
    input logic sec_pwr_ok,
    input logic rx_pulse_vld,
    input logic rx_pulse_lvl,
    input logic data_out,
    input logic data_valid
);
    import iso_chan_pkg::*;

    localparam int unsigned WIN = quiet_window(REFRESH_CYC, WDOG_MARGIN);

    // Independent count of cycles since the last accepted pulse.
    logic [31:0] quiet_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q <= 32'(WIN);
        end else if (sec_pwr_ok && rx_pulse_vld) begin
            quiet_q <= '0;
        end else if (quiet_q < 32'(WIN)) begin
            quiet_q <= quiet_q + 1;
        end
    end

    a_r2_unpowered_low: assert property (@(posedge clk) disable iff (rst)
        !sec_pwr_ok |=> (!data_out && !data_valid));

    a_r3_low_until_valid: assert property (@(posedge clk) disable iff (rst)
        !data_valid |-> !data_out);

    a_r4_pulse_loads: assert property (@(posedge clk) disable iff (rst)
        (sec_pwr_ok && rx_pulse_vld) |=> (data_valid && data_out == $past(rx_pulse_lvl)));

    a_r5_quiet_expiry: assert property (@(posedge clk) disable iff (rst)
        (quiet_q >= 32'(WIN - 1) && !rx_pulse_vld) |=> !data_valid);

    a_r6_hold_in_window: assert property (@(posedge clk) disable iff (rst)
        (data_valid && sec_pwr_ok && !rx_pulse_vld && quiet_q < 32'(WIN - 1))
        |=> (data_valid && $stable(data_out)));

    a_r8_tx_idle: assert property (@(posedge clk) disable iff (rst)
        !pri_pwr_ok |=> !tx_pulse_vld);

    a_r9_prime_pulse: assert property (@(posedge clk) disable iff (rst)
        $rose(pri_pwr_ok) |=> (tx_pulse_vld && tx_pulse_lvl == $past(data_in)));

    a_r10_edge_pulse: assert property (@(posedge clk) disable iff (rst)
        (pri_pwr_ok && $past(pri_pwr_ok) && data_in != $past(data_in))
        |=> (tx_pulse_vld && tx_pulse_lvl == $past(data_in)));

endmodule

bind iso_chan_link iso_chan_link_chk #(
    .REFRESH_CYC (REFRESH_CYC),
    .WDOG_MARGIN (WDOG_MARGIN)
) u_chk (.*);

// File: tb/iso_chan_link_tb.sv
`timescale 1ns/1ps
module iso_chan_link_tb;

    localparam int REF = 16;
    localparam int MAR = 4;
    localparam int WIN = 2 * REF + MAR;

    localparam int S_OUT = 0, S_VAL = 1, S_TXV = 2, S_TXL = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pri_pwr_ok = 1'b0, sec_pwr_ok = 1'b0, data_in = 1'b0;
    logic inj_en = 1'b1, inj_vld = 1'b0, inj_lvl = 1'b0, cut = 1'b0;
    logic tx_pulse_vld, tx_pulse_lvl, rx_pulse_vld, rx_pulse_lvl;
    logic data_out, data_valid;

    int cyc = 0;
    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    typedef struct {
        int    when;
        int    sig;
        bit    val;
        string tag;
    } exp_t;
    exp_t sb[$];

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign rx_pulse_vld = inj_en ? inj_vld : (tx_pulse_vld & ~cut);
    assign rx_pulse_lvl = inj_en ? inj_lvl : tx_pulse_lvl;

    iso_chan_link #(.REFRESH_CYC(REF), .WDOG_MARGIN(MAR)) u_dut (
        .clk(clk), .rst(rst), .pri_pwr_ok(pri_pwr_ok), .data_in(data_in),
        .tx_pulse_vld(tx_pulse_vld), .tx_pulse_lvl(tx_pulse_lvl),
        .sec_pwr_ok(sec_pwr_ok), .rx_pulse_vld(rx_pulse_vld),
        .rx_pulse_lvl(rx_pulse_lvl), .data_out(data_out), .data_valid(data_valid)
    );

    function automatic bit sig_now(input int s);
        case (s)
            S_OUT:   return data_out;
            S_VAL:   return data_valid;
            S_TXV:   return tx_pulse_vld;
            default: return tx_pulse_lvl;
        endcase
    endfunction

    // Monitor: pops every item due this cycle and compares.
    always @(negedge clk) begin
        for (int i = sb.size() - 1; i >= 0; i--) begin
            if (sb[i].when == cyc) begin
                n_checks++;
                if (sig_now(sb[i].sig) !== sb[i].val) begin
                    n_fails++;
                    $display("FAIL %s: signal %0d at cycle %0d actual %0b expected %0b",
                             sb[i].tag, sb[i].sig, cyc, sig_now(sb[i].sig), sb[i].val);
                end
                sb.delete(i);
            end else if (sb[i].when < cyc) begin
                n_checks++;
                n_fails++;
                $display("FAIL %s: item for cycle %0d never sampled actual x expected %0b",
                         sb[i].tag, sb[i].when, sb[i].val);
                sb.delete(i);
            end
        end
    end

    task automatic expect_at(input int when, input int s, input bit v, input string tag);
        exp_t e;
        e.when = when; e.sig = s; e.val = v; e.tag = tag;
        sb.push_back(e);
    endtask

    task automatic expect_rx(input int when, input bit o, input bit v, input string tag);
        expect_at(when, S_OUT, o, tag);
        expect_at(when, S_VAL, v, tag);
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    // Injected pulse; on return cyc is the edge that sampled it.
    task automatic inject(input bit lvl);
        inj_vld = 1'b1;
        inj_lvl = lvl;
        tick();
        inj_vld = 1'b0;
    endtask

    initial begin
        int e;
        int m;
        tick();
        // R1: reset state
        expect_rx(cyc + 1, 1'b0, 1'b0, "R1");
        expect_at(cyc + 1, S_TXV, 1'b0, "R1");
        pri_pwr_ok = 1'b1;
        idle(2);
        rst = 1'b0;
        pri_pwr_ok = 1'b0;

        // R8: unpowered transmitter stays silent while input toggles
        for (int i = 0; i < 8; i++) begin
            data_in = ~data_in;
            expect_at(cyc + 1, S_TXV, 1'b0, "R8");
            tick();
        end

        // R2: pulse while receiver unpowered has no effect
        expect_rx(cyc + 1, 1'b0, 1'b0, "R2");
        expect_rx(cyc + 2, 1'b0, 1'b0, "R2");
        inject(1'b1);
        tick();

        // R3: powered but no pulse yet -> low and not valid
        sec_pwr_ok = 1'b1;
        for (int k = 1; k <= 6; k++) expect_rx(cyc + k, 1'b0, 1'b0, "R3");
        idle(6);
        expect_rx(cyc, 1'b0, 1'b0, "R3");
        inject(1'b1);
        expect_rx(cyc, 1'b1, 1'b1, "R3");
        idle(3);

        // R4: edge to low then refresh-style pulse back high
        inject(1'b0);
        expect_rx(cyc, 1'b0, 1'b1, "R4");
        idle(2);
        inject(1'b1);
        expect_rx(cyc, 1'b1, 1'b1, "R4");

        // R5: quiet window expiry boundary
        e = cyc;
        expect_rx(e + WIN - 1, 1'b1, 1'b1, "R5");
        expect_rx(e + WIN, 1'b0, 1'b0, "R5");
        idle(WIN + 3);

        // R6: gap of two refresh periods does not drop the output
        inject(1'b1);
        e = cyc;
        expect_rx(e + 2 * REF - 1, 1'b1, 1'b1, "R6");
        idle(2 * REF - 1);
        inject(1'b1);
        expect_rx(cyc, 1'b1, 1'b1, "R6");
        expect_rx(cyc + 1, 1'b1, 1'b1, "R6");
        idle(3);

        // R7: loss of receiver power
        expect_rx(cyc, 1'b1, 1'b1, "R7");
        sec_pwr_ok = 1'b0;
        expect_rx(cyc + 1, 1'b0, 1'b0, "R7");
        idle(3);

        // End-to-end through the transmitter
        sec_pwr_ok = 1'b1;
        inj_en = 1'b0;
        idle(2);
        data_in = 1'b1;
        pri_pwr_ok = 1'b1;
        m = cyc;
        expect_at(m + 1, S_TXV, 1'b1, "R9");
        expect_at(m + 1, S_TXL, 1'b1, "R9");
        expect_at(m + 2, S_TXV, 1'b0, "R9");
        expect_rx(m + 2, 1'b1, 1'b1, "R3");
        expect_at(m + REF, S_TXV, 1'b0, "R11");
        expect_at(m + 1 + REF, S_TXV, 1'b1, "R11");
        expect_at(m + 1 + REF, S_TXL, 1'b1, "R11");
        expect_at(m + 2 + REF, S_TXV, 1'b0, "R11");
        expect_at(m + 1 + 2 * REF, S_TXV, 1'b1, "R11");
        idle(2 * REF + 4);

        // R10 / R12: input falls
        data_in = 1'b0;
        m = cyc;
        expect_at(m + 1, S_TXV, 1'b1, "R10");
        expect_at(m + 1, S_TXL, 1'b0, "R10");
        expect_rx(m + 1, 1'b1, 1'b1, "R12");
        expect_rx(m + 2, 1'b0, 1'b1, "R12");
        // R6 through the link: drop the first refresh at the barrier
        expect_at(m + 1 + REF, S_TXV, 1'b1, "R11");
        expect_rx(m + 30, 1'b0, 1'b1, "R6");
        expect_rx(m + 36, 1'b0, 1'b1, "R6");
        idle(1 + REF);
        cut = 1'b1;
        tick();
        cut = 1'b0;
        idle(22);

        // R12: input rises
        data_in = 1'b1;
        m = cyc;
        expect_rx(m + 1, 1'b0, 1'b1, "R12");
        expect_rx(m + 2, 1'b1, 1'b1, "R12");
        idle(4);

        // R8: transmitter power loss silences it
        pri_pwr_ok = 1'b0;
        for (int i = 0; i < 5; i++) begin
            data_in = ~data_in;
            expect_at(cyc + 1, S_TXV, 1'b0, "R8");
            tick();
        end
        idle(3);

        if (sb.size() != 0) begin
            n_fails += sb.size();
            $display("FAIL R1: %0d scoreboard items left actual %0d expected 0",
                     sb.size(), sb.size());
        end
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run hung actual running expected done");
            $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule